// File: doc/BRIEF.md
# Inbound I/O Request Router

This block picks a destination for each I/O-space request that arrives from one of the downstream PCIe ports. A request carries an address. The block compares that address against the current routing configuration: a master enable, a flag that sends legacy display traffic upstream, a display-claim bit for each port, an I/O window for each port, a local peer-to-peer window, a global peer-to-peer window, and a flag that says whether the legacy bridge port takes subtractive decode. From these it picks one of four destinations: the uplink, one downstream port (given by its index), the legacy bridge port, or master abort.

Requests enter through a valid/ready handshake. The decision is held in an output register and appears on the cycle after the request is accepted. The block samples the configuration at the same edge that accepts the request. It moves no data and builds no completions.

Top module: `inb_io_router`

## Requirements
- R1: While `cfg_io_en` is 0, every request resolves to master abort, whatever its address.
- R2: A request whose address is 0x10000 or higher (any bit above bit 15 set) resolves to master abort.
- R3: The legacy display ranges are 0x3B0–0x3BB and 0x3C0–0x3DF. An address in either range goes to the uplink when `cfg_vga_up` is 1, or when the address lies outside the local window but inside the global window.
- R4: A display-range address that does not go to the uplink goes to the lowest-numbered port whose `cfg_vga_claim` bit is set. If no port claims display traffic, it goes to the lowest-numbered port whose I/O window contains the address.
- R5: A display-range address that reaches no port goes to the bridge port when `cfg_bridge_subtr` is 1, and to master abort otherwise.
- R6: Any other address inside the local window goes to the lowest-numbered port whose I/O window contains it. If no port window contains it, it goes to the bridge port when `cfg_bridge_subtr` is 1, and to master abort otherwise.
- R7: A non-display address outside the local window but inside the global window goes to the uplink.
- R8: Any other address below 0x10000 goes to the bridge port when `cfg_bridge_subtr` is 1, and to master abort otherwise.
- R9: Every window includes both its base and its limit. A window whose limit is below its base matches no address.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at one edge shows up on `rsp_valid`/`rsp_dest`/`rsp_port` after that edge. The response stays unchanged while `rsp_valid` is 1 and `rsp_ready` is 0.
- R11: `rsp_dest` uses this encoding: 0 = uplink, 1 = downstream port, 2 = bridge port, 3 = master abort. `rsp_port` holds the port index when `rsp_dest` is 1, and is 0 for every other destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The router can accept a request |
| req_addr | input | 32 | I/O address of the request |
| cfg_io_en | input | 1 | Master enable for inbound I/O |
| cfg_vga_up | input | 1 | Send display-range traffic to the uplink |
| cfg_vga_claim | input | 4 | Display-claim bit for each port |
| cfg_bridge_subtr | input | 1 | Bridge port takes subtractive decode |
| cfg_port_base | input | 64 | Window base for each port, 16 bits per port, port 0 in the low bits |
| cfg_port_limit | input | 64 | Window limit for each port, packed the same way |
| cfg_loc_base | input | 16 | Local peer-to-peer window base |
| cfg_loc_limit | input | 16 | Local peer-to-peer window limit |
| cfg_glb_base | input | 16 | Global peer-to-peer window base |
| cfg_glb_limit | input | 16 | Global peer-to-peer window limit |
| rsp_valid | output | 1 | A routing decision is held |
| rsp_ready | input | 1 | The consumer takes the decision |
| rsp_dest | output | 2 | Destination class |
| rsp_port | output | 2 | Port index for a downstream port destination |

## Verification
The bench sweeps every address from 0x380 to 0x3FF across 32 configurations. This covers the edges of both display ranges: 0x3AF, 0x3BC and 0x3BF must not count as display addresses. A design with an off-by-one range check would send those addresses down the wrong branch. The configurations include overlapping port windows, single-address windows and empty windows. A design that did not pick the lowest port, treated a limit as exclusive, or let an inverted window match would name the wrong port or miss a subtractive fallback.

Addresses just above and below 64 KB check that a design does not keep only the low 16 bits, which would turn an abort into a routed request. The bench also checks the master enable with the bridge flag set, and it holds a response under backpressure. A design that dropped the enable gate or overwrote a held response would report the wrong destination.

// File: rtl/inb_io_pkg.sv
package inb_io_pkg;

  typedef enum logic [1:0] {
    DEST_UPLINK = 2'd0,
    DEST_PORT   = 2'd1,
    DEST_BRIDGE = 2'd2,
    DEST_ABORT  = 2'd3
  } route_dest_t;

  localparam int unsigned IO_SPACE_BITS = 16;

  localparam logic [IO_SPACE_BITS-1:0] VGA_MONO_LO  = 16'h03B0;
  localparam logic [IO_SPACE_BITS-1:0] VGA_MONO_HI  = 16'h03BB;
  localparam logic [IO_SPACE_BITS-1:0] VGA_COLOR_LO = 16'h03C0;
  localparam logic [IO_SPACE_BITS-1:0] VGA_COLOR_HI = 16'h03DF;

endpackage

// File: rtl/inb_io_win_cmp.sv
module inb_io_win_cmp #(
  parameter int unsigned IO_W = 16
) (
  input  logic [IO_W-1:0] addr,
  input  logic [IO_W-1:0] win_base,
  input  logic [IO_W-1:0] win_limit,
  output logic            hit
);
  // Inclusive at both ends; an inverted window cannot satisfy both compares.
  always_comb begin
    hit = (addr >= win_base) && (addr <= win_limit);
  end
endmodule

// File: rtl/inb_io_prio.sv
module inb_io_prio #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/inb_io_decide.sv
module inb_io_decide
  import inb_io_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned IO_W   = 16,
  parameter int unsigned PIDX_W = 2
) (
  input  logic [IO_W-1:0]   io_addr,
  input  logic              addr_high,
  input  logic              io_en,
  input  logic              vga_up,
  input  logic              bridge_subtr,
  input  logic              in_loc,
  input  logic              in_glb,
  input  logic [NPORTS-1:0] vga_claim,
  input  logic [NPORTS-1:0] port_hit,
  output route_dest_t       dest,
  output logic [PIDX_W-1:0] port
);

  logic              claim_any;
  logic [PIDX_W-1:0] claim_idx;
  logic              hit_any;
  logic [PIDX_W-1:0] hit_idx;
  logic              is_vga;
  route_dest_t       fallback;

  inb_io_prio #(.N(NPORTS), .IW(PIDX_W)) u_claim_prio (
    .req (vga_claim),
    .any (claim_any),
    .idx (claim_idx)
  );

  inb_io_prio #(.N(NPORTS), .IW(PIDX_W)) u_hit_prio (
    .req (port_hit),
    .any (hit_any),
    .idx (hit_idx)
  );

  always_comb begin
    is_vga = ((io_addr >= VGA_MONO_LO)  && (io_addr <= VGA_MONO_HI)) ||
             ((io_addr >= VGA_COLOR_LO) && (io_addr <= VGA_COLOR_HI));
    fallback = bridge_subtr ? DEST_BRIDGE : DEST_ABORT;
  end

  always_comb begin
    dest = DEST_ABORT;
    port = '0;
    if (!io_en || addr_high) begin
      dest = DEST_ABORT;
    end else if (is_vga) begin
      if (vga_up || (!in_loc && in_glb)) begin
        dest = DEST_UPLINK;
      end else if (claim_any) begin
        dest = DEST_PORT;
        port = claim_idx;
      end else if (hit_any) begin
        dest = DEST_PORT;
        port = hit_idx;
      end else begin
        dest = fallback;
      end
    end else if (in_loc) begin
      if (hit_any) begin
        dest = DEST_PORT;
        port = hit_idx;
      end else begin
        dest = fallback;
      end
    end else if (in_glb) begin
      dest = DEST_UPLINK;
    end else begin
      dest = fallback;
    end
  end

endmodule

// File: rtl/inb_io_router.sv
module inb_io_router
  import inb_io_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IO_W   = IO_SPACE_BITS,
  localparam int unsigned PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   cfg_io_en,
  input  logic                   cfg_vga_up,
  input  logic [NPORTS-1:0]      cfg_vga_claim,
  input  logic                   cfg_bridge_subtr,
  input  logic [NPORTS*IO_W-1:0] cfg_port_base,
  input  logic [NPORTS*IO_W-1:0] cfg_port_limit,
  input  logic [IO_W-1:0]        cfg_loc_base,
  input  logic [IO_W-1:0]        cfg_loc_limit,
  input  logic [IO_W-1:0]        cfg_glb_base,
  input  logic [IO_W-1:0]        cfg_glb_limit,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [1:0]             rsp_dest,
  output logic [PIDX_W-1:0]      rsp_port
);

  logic [IO_W-1:0]   io_addr;
  logic              addr_high;
  logic [NPORTS-1:0] port_hit;
  logic              in_loc;
  logic              in_glb;
  route_dest_t       dec_dest;
  logic [PIDX_W-1:0] dec_port;

  logic              accept;
  logic              valid_d, valid_q;
  logic [1:0]        dest_d, dest_q;
  logic [PIDX_W-1:0] port_d, port_q;

  assign io_addr   = req_addr[IO_W-1:0];
  assign addr_high = |req_addr[ADDR_W-1:IO_W];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port_win
    inb_io_win_cmp #(.IO_W(IO_W)) u_win (
      .addr      (io_addr),
      .win_base  (cfg_port_base[p*IO_W +: IO_W]),
      .win_limit (cfg_port_limit[p*IO_W +: IO_W]),
      .hit       (port_hit[p])
    );
  end

  inb_io_win_cmp #(.IO_W(IO_W)) u_loc_win (
    .addr      (io_addr),
    .win_base  (cfg_loc_base),
    .win_limit (cfg_loc_limit),
    .hit       (in_loc)
  );

  inb_io_win_cmp #(.IO_W(IO_W)) u_glb_win (
    .addr      (io_addr),
    .win_base  (cfg_glb_base),
    .win_limit (cfg_glb_limit),
    .hit       (in_glb)
  );

  inb_io_decide #(.NPORTS(NPORTS), .IO_W(IO_W), .PIDX_W(PIDX_W)) u_decide (
    .io_addr      (io_addr),
    .addr_high    (addr_high),
    .io_en        (cfg_io_en),
    .vga_up       (cfg_vga_up),
    .bridge_subtr (cfg_bridge_subtr),
    .in_loc       (in_loc),
    .in_glb       (in_glb),
    .vga_claim    (cfg_vga_claim),
    .port_hit     (port_hit),
    .dest         (dec_dest),
    .port         (dec_port)
  );

  // Next-state logic for the output stage
  always_comb begin
    req_ready = !valid_q || rsp_ready;
    accept    = req_valid && req_ready;
    valid_d   = valid_q;
    dest_d    = dest_q;
    port_d    = port_q;
    if (accept) begin
      valid_d = 1'b1;
      dest_d  = dec_dest;
      port_d  = dec_port;
    end else if (rsp_ready) begin
      valid_d = 1'b0;
    end
  end

  // Output register; payload loads only on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= DEST_ABORT;
      port_q <= '0;
    end else if (accept) begin
      dest_q <= dest_d;
      port_q <= port_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_dest  = dest_q;
  assign rsp_port  = port_q;

  p_off_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_io_en) |=> (rsp_valid && rsp_dest == DEST_ABORT));

  p_high_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && |req_addr[ADDR_W-1:IO_W]) |=> (rsp_valid && rsp_dest == DEST_ABORT));

  p_accept_shows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_dest) && $stable(rsp_port)));

  p_port_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_dest != DEST_PORT) |-> (rsp_port == '0));

endmodule

// File: tb/tb_inb_io_router.sv
module tb_inb_io_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        cfg_io_en;
  logic        cfg_vga_up;
  logic [3:0]  cfg_vga_claim;
  logic        cfg_bridge_subtr;
  logic [63:0] cfg_port_base;
  logic [63:0] cfg_port_limit;
  logic [15:0] cfg_loc_base, cfg_loc_limit, cfg_glb_base, cfg_glb_limit;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [1:0]  rsp_dest;
  logic [1:0]  rsp_port;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  inb_io_router dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .cfg_io_en (cfg_io_en), .cfg_vga_up (cfg_vga_up),
    .cfg_vga_claim (cfg_vga_claim), .cfg_bridge_subtr (cfg_bridge_subtr),
    .cfg_port_base (cfg_port_base), .cfg_port_limit (cfg_port_limit),
    .cfg_loc_base (cfg_loc_base), .cfg_loc_limit (cfg_loc_limit),
    .cfg_glb_base (cfg_glb_base), .cfg_glb_limit (cfg_glb_limit),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
    .rsp_dest (rsp_dest), .rsp_port (rsp_port)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a, input logic [15:0] b, input logic [15:0] l);
    return (a >= b) && (a <= l);
  endfunction

  // Returns {dest, port} from the requirement text
  function automatic logic [3:0] model(input logic [31:0] a);
    logic [15:0] lo = a[15:0];
    logic [1:0]  fb = cfg_bridge_subtr ? 2'd2 : 2'd3;
    bit vga = (lo >= 16'h03B0 && lo <= 16'h03BB) || (lo >= 16'h03C0 && lo <= 16'h03DF);
    bit loc = in_win(lo, cfg_loc_base, cfg_loc_limit);
    bit glb = in_win(lo, cfg_glb_base, cfg_glb_limit);
    int first_claim = -1;
    int first_hit = -1;
    for (int p = 3; p >= 0; p--) begin
      if (cfg_vga_claim[p]) first_claim = p;
      if (in_win(lo, cfg_port_base[p*16 +: 16], cfg_port_limit[p*16 +: 16])) first_hit = p;
    end
    if (!cfg_io_en) return 4'b1100;
    if (a >= 32'h10000) return 4'b1100;
    if (vga) begin
      if (cfg_vga_up || (!loc && glb)) return 4'b0000;
      if (first_claim >= 0) return {2'd1, 2'(first_claim)};
      if (first_hit >= 0) return {2'd1, 2'(first_hit)};
      return {fb, 2'd0};
    end
    if (loc) begin
      if (first_hit >= 0) return {2'd1, 2'(first_hit)};
      return {fb, 2'd0};
    end
    if (glb) return 4'b0000;
    return {fb, 2'd0};
  endfunction

  function automatic string tag(input logic [31:0] a);
    logic [15:0] lo = a[15:0];
    if (!cfg_io_en) return "R1";
    if (a >= 32'h10000) return "R2";
    if ((lo >= 16'h03B0 && lo <= 16'h03BB) || (lo >= 16'h03C0 && lo <= 16'h03DF)) return "R3/R4/R5";
    if (in_win(lo, cfg_loc_base, cfg_loc_limit)) return "R6/R9";
    if (in_win(lo, cfg_glb_base, cfg_glb_limit)) return "R7";
    return "R8";
  endfunction

  task automatic send(input logic [31:0] a);
    logic [3:0] e;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    e = model(a);
    @(negedge clk);
    req_valid = 1'b0;
    check({"R10 valid ", tag(a)}, {31'd0, rsp_valid}, 32'd1);
    check({"R11 ", tag(a)}, {28'd0, rsp_dest, rsp_port}, {28'd0, e});
  endtask

  task automatic set_cfg(input int c);
    cfg_io_en        = 1'b1;
    cfg_vga_up       = c[0];
    cfg_bridge_subtr = c[1];
    case (c[3:2])
      2'd0: cfg_vga_claim = 4'b0000;
      2'd1: cfg_vga_claim = 4'b0100;
      2'd2: cfg_vga_claim = 4'b1010;
      default: cfg_vga_claim = 4'b0000;
    endcase
    if (!c[4]) begin
      // port0 3B8-3C3, port1 1000-1FFF, port2 empty, port3 3C2-3DF (overlaps port0)
      cfg_port_base  = {16'h03C2, 16'h03D5, 16'h1000, 16'h03B8};
      cfg_port_limit = {16'h03DF, 16'h03D0, 16'h1FFF, 16'h03C3};
      cfg_loc_base   = 16'h0300;
    end else begin
      // port0 empty, port1 single address 3B0, port2 300-3BF, port3 2000-2FFF
      cfg_port_base  = {16'h2000, 16'h0300, 16'h03B0, 16'h0001};
      cfg_port_limit = {16'h2FFF, 16'h03BF, 16'h03B0, 16'h0000};
      cfg_loc_base   = 16'h03C8;
    end
    cfg_loc_limit = 16'h2FFF;
    cfg_glb_base  = 16'h0000;
    cfg_glb_limit = 16'h7FFF;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] edges [12];
    logic [3:0]  e_a, e_b;
    edges = '{32'h0, 32'h02FF, 32'h1000, 32'h1FFF, 32'h2000, 32'h2FFF,
              32'h3000, 32'h7FFF, 32'h8000, 32'hFFFF, 32'h10000, 32'hFFFF_FFFF};
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    rsp_ready = 1'b1;
    set_cfg(0);
    repeat (3) @(negedge clk);
    check("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R10 reset req_ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;

    for (int c = 0; c < 32; c++) begin
      set_cfg(c);
      for (int a = 32'h380; a < 32'h400; a++) send(32'(a));
      for (int k = 0; k < 12; k++) send(edges[k]);
    end

    // R1: enable off overrides bridge and uplink paths
    set_cfg(2);
    cfg_io_en = 1'b0;
    send(32'h03B0);
    send(32'h1000);
    send(32'h4000);
    send(32'h9000);

    // R2: address just above 64 KB aliases a routable low address
    set_cfg(2);
    send(32'h0001_1000);
    send(32'h0001_03C0);

    // R10: backpressure holds the response and blocks new requests
    set_cfg(0);
    @(negedge clk);
    rsp_ready = 1'b0;
    e_a = model(32'h1000);
    e_b = model(32'h4000);
    req_valid = 1'b1; req_addr = 32'h1000;
    @(negedge clk);
    req_addr = 32'h4000;
    check("R10 ready low while held", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    check("R10 held valid", {31'd0, rsp_valid}, 32'd1);
    check("R10 held payload", {28'd0, rsp_dest, rsp_port}, {28'd0, e_a});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 next payload", {28'd0, rsp_dest, rsp_port}, {28'd0, e_b});
    @(negedge clk);
    check("R10 drains", {31'd0, rsp_valid}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule